// File: doc/BRIEF.md
# Cascaded Real-Time Clock with Interrupt Events

This block keeps time with five counters in a chain, all advanced by a single 5 ms timebase enable pulse. The first stage counts 5 ms steps and completes a full lap every second. The second stage counts seconds. The remaining three count minutes, blocks of 256 minutes and blocks of 65,536 minutes. A stage moves by one only in the cycle in which every stage below it wraps.

Three events are drawn from the chain: a tick on every second timebase pulse (100 per second), a second event and a minute event. Each event sets a sticky status bit, whether or not that bit is enabled. The interrupt line is high while any status bit is set together with its enable mask bit. Software clears a status bit by writing 1 to the matching acknowledge bit. A hold control forces every counter to zero and keeps it there for as long as the control is high.

Top module: `rtc_chain_irq`

## Requirements
- R1: `cnt0_o` (8 bits) advances by one on each clock edge with `tb_en` high (and `hold_clr` low). It goes from 199 back to 0, and it keeps its value when `tb_en` is low.
- R2: `cnt1_o` (6 bits) advances only on the edge where `cnt0_o` wraps, and goes from 59 back to 0.
- R3: `cnt2_o` (8 bits, wraps after 255), `cnt3_o` (8 bits, wraps after 255) and `cnt4_o` (5 bits, wraps after 31) each advance only on the edge where the stage below wraps. When the whole chain wraps, every counter returns to 0 together.
- R4: While `hold_clr` is high, all counters are 0 after the next edge, do not advance and raise no events. Once `hold_clr` is low again, counting resumes from 0.
- R5: Status bit 0 (tick) is set on every timebase pulse that moves `cnt0_o` from an odd value to the next value. This gives 100 ticks per 200 pulses.
- R6: Status bit 1 (second) is set on the pulse where `cnt0_o` wraps. Status bit 2 (minute) is set on the pulse where `cnt0_o` and `cnt1_o` wrap together.
- R7: An edge with `ack_we` high clears every status bit whose `ack_wdata` bit is 1. Status bits written 0 are unchanged. Without an acknowledge, a set status bit stays set.
- R8: If an event and its acknowledge arrive on the same edge, the status bit ends set.
- R9: An edge with `mask_we` high loads `mask_wdata` as the enable mask, using the same bit order as the status bits. `irq_o` is the OR of status AND mask. Status bits are set regardless of the mask.
- R10: While `rst_n` is low, all counters, the status and the mask are 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | 5 ms timebase enable, one cycle per step |
| hold_clr | input | 1 | Hold all counters at zero while high |
| mask_we | input | 1 | Enable mask write strobe |
| mask_wdata | input | 3 | New mask (bit 0 tick, 1 second, 2 minute) |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_wdata | input | 3 | Status bits to clear |
| status_o | output | 3 | Sticky event status |
| irq_o | output | 1 | Interrupt request |
| cnt0_o | output | 8 | 5 ms step count, 0..199 |
| cnt1_o | output | 6 | Seconds, 0..59 |
| cnt2_o | output | 8 | Minutes, 0..255 |
| cnt3_o | output | 8 | 256-minute units, 0..255 |
| cnt4_o | output | 5 | 65,536-minute units, 0..31 |

## Verification
The bench counts ticks over a full second, one at a time. A design that fired on every pulse would report 200 ticks, and one tied to the wrong parity would be off at the second boundary. It runs one pulse short of a minute and then one pulse past it, to catch an off-by-one in the 199 or 59 limits or a minute event that lands on the wrong edge. It issues an acknowledge in the same cycle as a fresh tick: a design that let the acknowledge win would lose that event. It also acknowledges single bits, to catch an acknowledge that wipes every status bit. A second instance with tiny moduli walks the full chain through its wrap, which catches a carry that skips a stage or a final stage that fails to return to zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NSTAGE = 5;
    localparam int EV_N   = 3;

    typedef enum int {
        EV_TICK = 0,
        EV_SEC  = 1,
        EV_MIN  = 2
    } rtc_ev_e;
endpackage

// File: rtl/rtc_stage.sv
module rtc_stage #(
    parameter int unsigned MOD = 200,
    parameter int          W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = inc_i && !clr_i && (st_q.cnt == LAST);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         ack_we,
    input  logic [N-1:0] ack_wdata,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] status;
        logic [N-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;
    logic [N-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = ack_we ? ack_wdata : '0;
        // new events override a same-cycle acknowledge
        st_d.status = (st_q.status & ~clr_bits) | evt_i;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & st_q.mask);
endmodule

// File: rtl/rtc_chain_irq.sv
module rtc_chain_irq #(
    parameter int unsigned MOD0     = 200,
    parameter int unsigned MOD1     = 60,
    parameter int unsigned MOD2     = 256,
    parameter int unsigned MOD3     = 256,
    parameter int unsigned MOD4     = 32,
    parameter int unsigned TICK_DIV = 2,
    localparam int W0 = $clog2(MOD0),
    localparam int W1 = $clog2(MOD1),
    localparam int W2 = $clog2(MOD2),
    localparam int W3 = $clog2(MOD3),
    localparam int W4 = $clog2(MOD4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tb_en,
    input  logic          hold_clr,
    input  logic          mask_we,
    input  logic [2:0]    mask_wdata,
    input  logic          ack_we,
    input  logic [2:0]    ack_wdata,
    output logic [2:0]    status_o,
    output logic          irq_o,
    output logic [W0-1:0] cnt0_o,
    output logic [W1-1:0] cnt1_o,
    output logic [W2-1:0] cnt2_o,
    output logic [W3-1:0] cnt3_o,
    output logic [W4-1:0] cnt4_o
);
    import rtc_pkg::*;

    localparam int          NST = NSTAGE;
    localparam int unsigned MODV [NST] = '{MOD0, MOD1, MOD2, MOD3, MOD4};

    logic [NST-1:0]  wrap;
    logic [EV_N-1:0] evt;
    logic            tick_ev;

    for (genvar g = 0; g < NST; g++) begin : g_stage
        localparam int unsigned M = MODV[g];
        localparam int          W = $clog2(M);
        logic [W-1:0] c;
        logic         inc;

        if (g == 0) begin : g_first
            assign inc = tb_en;
        end else begin : g_next
            assign inc = wrap[g-1];
        end

        rtc_stage #(.MOD(M), .W(W)) u_stg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (hold_clr),
            .inc_i (inc),
            .cnt_o (c),
            .wrap_o(wrap[g])
        );

        case (g)
            0:       begin : g_o0 assign cnt0_o = c; end
            1:       begin : g_o1 assign cnt1_o = c; end
            2:       begin : g_o2 assign cnt2_o = c; end
            3:       begin : g_o3 assign cnt3_o = c; end
            default: begin : g_o4 assign cnt4_o = c; end
        endcase
    end

    assign tick_ev = tb_en && !hold_clr
                     && ((32'(cnt0_o) % TICK_DIV) == (TICK_DIV - 1));

    always_comb begin
        evt          = '0;
        evt[EV_TICK] = tick_ev;
        evt[EV_SEC]  = wrap[0];
        evt[EV_MIN]  = wrap[1];
    end

    rtc_irq_ctrl #(.N(EV_N)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .ack_we    (ack_we),
        .ack_wdata (ack_wdata),
        .status_o  (status_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/rtc_chain_irq_chk.sv
module rtc_chain_irq_chk #(
    parameter int unsigned MOD0 = 200,
    parameter int unsigned MOD1 = 60,
    parameter int unsigned MOD2 = 256,
    parameter int unsigned MOD3 = 256,
    parameter int unsigned MOD4 = 32,
    localparam int W0 = $clog2(MOD0),
    localparam int W1 = $clog2(MOD1),
    localparam int W2 = $clog2(MOD2),
    localparam int W3 = $clog2(MOD3),
    localparam int W4 = $clog2(MOD4)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tb_en,
    input logic          hold_clr,
    input logic          ack_we,
    input logic [2:0]    ack_wdata,
    input logic [2:0]    status_o,
    input logic          irq_o,
    input logic [W0-1:0] cnt0_o,
    input logic [W1-1:0] cnt1_o,
    input logic [W2-1:0] cnt2_o,
    input logic [W3-1:0] cnt3_o,
    input logic [W4-1:0] cnt4_o,
    input logic          full_wrap
);
    localparam logic [W0-1:0] L0 = W0'(MOD0 - 1);
    localparam logic [W1-1:0] L1 = W1'(MOD1 - 1);

    logic all_zero;
    assign all_zero = (cnt0_o == '0) && (cnt1_o == '0) && (cnt2_o == '0)
                      && (cnt3_o == '0) && (cnt4_o == '0);

    p_cnt0_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt0_o <= L0);

    p_cnt0_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_en && !hold_clr) |=>
            (cnt0_o == (($past(cnt0_o) == L0) ? '0 : $past(cnt0_o) + 1'b1)));

    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_en && !hold_clr) |=>
            ($stable(cnt0_o) && $stable(cnt1_o) && $stable(cnt2_o)
             && $stable(cnt3_o) && $stable(cnt4_o)));

    p_cnt1_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt1_o <= L1);

    p_full_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_wrap |=> all_zero);

    p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> all_zero);

    p_hold_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> ((status_o & ~$past(status_o)) == 3'b000));

    p_min_with_sec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[2]) |-> status_o[1]);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !tb_en) |=> ((status_o & $past(ack_wdata)) == 3'b000));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_we |=> (($past(status_o) & ~status_o) == 3'b000));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'b000) |-> !irq_o);
endmodule

bind rtc_chain_irq rtc_chain_irq_chk #(
    .MOD0(MOD0), .MOD1(MOD1), .MOD2(MOD2), .MOD3(MOD3), .MOD4(MOD4)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tb_en    (tb_en),
    .hold_clr (hold_clr),
    .ack_we   (ack_we),
    .ack_wdata(ack_wdata),
    .status_o (status_o),
    .irq_o    (irq_o),
    .cnt0_o   (cnt0_o),
    .cnt1_o   (cnt1_o),
    .cnt2_o   (cnt2_o),
    .cnt3_o   (cnt3_o),
    .cnt4_o   (cnt4_o),
    .full_wrap(wrap[NST-1])
);

// File: tb/tb_rtc_chain_irq.sv
module tb_rtc_chain_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_en = 1'b0;
    logic       hold_clr = 1'b0;
    logic       mask_we = 1'b0;
    logic [2:0] mask_wdata = 3'b000;
    logic       ack_we = 1'b0;
    logic [2:0] ack_wdata = 3'b000;
    logic [2:0] status;
    logic       irq;
    logic [7:0] c0;
    logic [5:0] c1;
    logic [7:0] c2;
    logic [7:0] c3;
    logic [4:0] c4;

    // small-modulus instance for full-chain wrap
    logic       s_en = 1'b0;
    logic [2:0] s_status;
    logic       s_irq;
    logic [1:0] s0;
    logic [1:0] s1;
    logic       s2, s3, s4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rtc_chain_irq dut (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .hold_clr(hold_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ack_we(ack_we), .ack_wdata(ack_wdata),
        .status_o(status), .irq_o(irq),
        .cnt0_o(c0), .cnt1_o(c1), .cnt2_o(c2), .cnt3_o(c3), .cnt4_o(c4)
    );

    rtc_chain_irq #(.MOD0(4), .MOD1(3), .MOD2(2), .MOD3(2), .MOD4(2)) dut_s (
        .clk(clk), .rst_n(rst_n), .tb_en(s_en), .hold_clr(1'b0),
        .mask_we(1'b0), .mask_wdata(3'b000),
        .ack_we(1'b0), .ack_wdata(3'b000),
        .status_o(s_status), .irq_o(s_irq),
        .cnt0_o(s0), .cnt1_o(s1), .cnt2_o(s2), .cnt3_o(s3), .cnt4_o(s4)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        tb_en = 1'b1;
        repeat (n) @(negedge clk);
        tb_en = 1'b0;
    endtask

    task automatic pulse_s(input int n);
        s_en = 1'b1;
        repeat (n) @(negedge clk);
        s_en = 1'b0;
    endtask

    task automatic ack(input logic [2:0] bits);
        ack_we = 1'b1; ack_wdata = bits;
        @(negedge clk);
        ack_we = 1'b0; ack_wdata = 3'b000;
    endtask

    task automatic set_mask(input logic [2:0] bits);
        mask_we = 1'b1; mask_wdata = bits;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic clear_all();
        hold_clr = 1'b1; ack_we = 1'b1; ack_wdata = 3'b111;
        @(negedge clk);
        hold_clr = 1'b0; ack_we = 1'b0; ack_wdata = 3'b000;
    endtask

    task automatic t_reset();
        check("R10 cnt0 in reset", c0, 0);
        check("R10 cnt4 in reset", c4, 0);
        check("R10 status in reset", status, 0);
        check("R10 irq in reset", irq, 0);
    endtask

    task automatic t_tick();
        clear_all();
        pulse(1);
        check("R1 cnt0 after one pulse", c0, 1);
        check("R5 no tick on first pulse", status, 0);
        pulse(1);
        check("R1 cnt0 after two pulses", c0, 2);
        check("R5 tick on second pulse", status, 1);
        @(negedge clk);
        check("R1 cnt0 holds without tb_en", c0, 2);
    endtask

    task automatic t_tick_rate();
        int ticks = 0;
        clear_all();
        for (int i = 0; i < 200; i++) begin
            pulse(1);
            if (status[0]) ticks++;
            if (i == 198) check("R6 no second before wrap", status[1], 0);
            ack(3'b001);
        end
        check("R5 ticks per 200 pulses", ticks, 100);
        check("R6 second set on cnt0 wrap", status[1], 1);
        check("R1 cnt0 wrapped to 0", c0, 0);
        check("R2 cnt1 advanced once", c1, 1);
    endtask

    task automatic t_minute();
        clear_all();
        pulse(11999);
        check("R1 cnt0 at 199", c0, 199);
        check("R2 cnt1 at 59", c1, 59);
        check("R6 no minute yet", status[2], 0);
        pulse(1);
        check("R2 cnt1 wraps to 0", c1, 0);
        check("R3 cnt2 advanced", c2, 1);
        check("R6 minute event", status[2], 1);
    endtask

    task automatic t_hold();
        clear_all();
        pulse(7);
        ack(3'b111);
        hold_clr = 1'b1; tb_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 cnt0 held at zero", c0, 0);
        check("R4 no events under hold", status, 0);
        hold_clr = 1'b0; tb_en = 1'b0;
        pulse(3);
        check("R4 count resumes from zero", c0, 3);
    endtask

    task automatic t_irq();
        clear_all();
        set_mask(3'b000);
        pulse(2);
        check("R9 status set while masked", status, 1);
        check("R9 irq low when masked", irq, 0);
        set_mask(3'b001);
        check("R9 irq high when enabled", irq, 1);
        set_mask(3'b110);
        check("R9 irq low for other mask bits", irq, 0);
        set_mask(3'b000);
    endtask

    task automatic t_ack_bits();
        clear_all();
        pulse(200);
        check("R7 tick and second set", status, 3);
        ack(3'b001);
        check("R7 ack clears only tick", status, 2);
        ack(3'b000);
        check("R7 zero ack leaves status", status, 2);
        ack(3'b010);
        check("R7 ack clears second", status, 0);
    endtask

    task automatic t_ack_race();
        clear_all();
        pulse(3);
        check("R5 tick before race", status, 1);
        ack_we = 1'b1; ack_wdata = 3'b001; tb_en = 1'b1;
        @(negedge clk);
        ack_we = 1'b0; ack_wdata = 3'b000; tb_en = 1'b0;
        check("R8 event beats ack", status, 1);
        check("R1 cnt0 during race", c0, 4);
        ack(3'b001);
        check("R7 plain ack clears", status, 0);
    endtask

    task automatic t_cascade();
        pulse_s(12);
        check("R3 small cnt2 after 12", s2, 1);
        check("R3 small cnt1 zero after 12", s1, 0);
        pulse_s(83);
        check("R3 small cnt0 max", s0, 3);
        check("R3 small cnt1 max", s1, 2);
        check("R3 small upper max", {29'd0, s2, s3, s4}, 7);
        pulse_s(1);
        check("R3 chain wraps to zero",
              {26'd0, s0, s1, s2, s3, s4}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_tick();
        t_tick_rate();
        t_minute();
        t_hold();
        t_irq();
        t_ack_bits();
        t_ack_race();
        t_cascade();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule